// File: doc/BRIEF.md
# Zero-aware dual-precision residue scaler

This block divides a number held as four residues, over the moduli 2^(2N)+1, 2^(2N), 2^N+1 and 2^N−1 (taken in that order), by a constant. It does this without first converting the number back to binary. The logic is purely combinational and uses no lookup tables. It produces two quotients at the same time. The coarse quotient divides by the product of the first two moduli. The fine quotient divides by the first modulus alone. Both are returned in the same residue format as the input.

The two quotients share one core. That core computes the term H, the input's digit of weight 2^(2N)+1. It also computes the term T, which is the coarse quotient itself. The fine quotient is then formed from H and T using a few small modular adders.

A selector helps the caller avoid scaling a value down to zero. It returns the coarse quotient unless that quotient is all zero. In that case it returns the fine quotient, and if that is also all zero it passes the input through unchanged. A two-bit code reports which of the three was chosen. The choice comes from zero tests on the quotient residues, so no residue magnitude comparison is needed.

Top module: `rns_dual_scaler`

## Requirements
- R1: `hi2_o` equals floor(X/(2^(2N)+1)) mod 2^(2N), which is (x2 − x1) mod 2^(2N).
- R2: `lo1_o` and `lo2_o` both equal the coarse quotient floor(X/((2^(2N)+1)·2^(2N))).
- R3: `lo3_o` and `lo4_o` equal the coarse quotient reduced modulo 2^N+1 and modulo 2^N−1.
- R4: `hi1_o` equals the fine quotient floor(X/(2^(2N)+1)) reduced modulo 2^(2N)+1.
- R5: `hi3_o` and `hi4_o` equal the fine quotient reduced modulo 2^N+1 and modulo 2^N−1.
- R6: When any coarse residue is non-zero, `sel1_o`..`sel4_o` carry the coarse residues and `src_o` = 2'b00.
- R7: When all coarse residues are zero and any fine residue is non-zero, the selected outputs carry the fine residues and `src_o` = 2'b01.
- R8: When all coarse and all fine residues are zero, the selected outputs repeat the input residues and `src_o` = 2'b10. An all-zero input therefore gives an all-zero output with `src_o` = 2'b10.
- R9: Every output residue is strictly below its modulus. In particular, a residue modulo 2^N−1 never takes the all-ones code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x1_i | input | 2N+1 | Input residue modulo 2^(2N)+1 |
| x2_i | input | 2N | Input residue modulo 2^(2N) |
| x3_i | input | N+1 | Input residue modulo 2^N+1 |
| x4_i | input | N | Input residue modulo 2^N−1 |
| lo1_o | output | 2N+1 | Coarse quotient residue modulo 2^(2N)+1 |
| lo2_o | output | 2N | Coarse quotient residue modulo 2^(2N) |
| lo3_o | output | N+1 | Coarse quotient residue modulo 2^N+1 |
| lo4_o | output | N | Coarse quotient residue modulo 2^N−1 |
| hi1_o | output | 2N+1 | Fine quotient residue modulo 2^(2N)+1 |
| hi2_o | output | 2N | Fine quotient residue modulo 2^(2N) |
| hi3_o | output | N+1 | Fine quotient residue modulo 2^N+1 |
| hi4_o | output | N | Fine quotient residue modulo 2^N−1 |
| sel1_o | output | 2N+1 | Selected residue modulo 2^(2N)+1 |
| sel2_o | output | 2N | Selected residue modulo 2^(2N) |
| sel3_o | output | N+1 | Selected residue modulo 2^N+1 |
| sel4_o | output | N | Selected residue modulo 2^N−1 |
| src_o | output | 2 | Selection code: 00 coarse, 01 fine, 10 input |

## Verification
The coarse quotient, the fine quotient and the zero-aware choice are all settled by the same input word. Each swept value therefore tests the division and the selection together. With N=3 the bench visits every representable number. This drives all three selector branches:
- values at or above the product of the first two moduli take the coarse path;
- values between the first modulus and that product take the fine path;
- values below the first modulus take the pass-through path.

For each value the bench checks every residue and the source code against integer division and remainder done in the bench.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;
  typedef enum logic [1:0] {
    SRC_LOW  = 2'b00,
    SRC_HIGH = 2'b01,
    SRC_PASS = 2'b10
  } src_e;
endpackage

// File: rtl/rns_mod_addsub.sv
// Modular add or subtract for modulus 2^W-1 (PLUS=0) or 2^W+1 (PLUS=1).
module rns_mod_addsub #(
  parameter int W    = 4,
  parameter bit PLUS = 1'b0,
  parameter bit SUB  = 1'b0,
  localparam int RW  = W + (PLUS ? 1 : 0)
) (
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] b_i,
  output logic [RW-1:0] r_o
);
  generate
    if (PLUS) begin : g_plus
      localparam logic [W+1:0] MOD = (W+2)'((1 << W) + 1);
      logic [W+1:0] opb, sum;
      always_comb begin
        opb   = SUB ? (MOD - (W+2)'(b_i)) : (W+2)'(b_i);
        sum   = (W+2)'(a_i) + opb;
        if (sum >= MOD) sum = sum - MOD;
        r_o   = sum[RW-1:0];
      end
      always_comb begin
        AST_PLUS_BELOW_MOD: assert ((W+2)'(r_o) < MOD) else $error("residue not below 2^W+1"); // R9
      end
    end else begin : g_minus
      logic [W:0]   sum;
      logic [W-1:0] opb, fold;
      always_comb begin
        opb  = SUB ? ~b_i : b_i;
        sum  = {1'b0, a_i} + {1'b0, opb};
        fold = sum[W-1:0] + W'(sum[W]);
        r_o  = (&fold) ? '0 : fold;
      end
      always_comb begin
        AST_MINUS_SINGLE_ZERO: assert (!(&r_o)) else $error("all-ones zero code"); // R9
      end
    end
  endgenerate
endmodule

// File: rtl/rns_fold.sv
// Reduce a 2N-bit value modulo 2^N-1 (PLUS=0) or 2^N+1 (PLUS=1).
module rns_fold #(
  parameter int N    = 4,
  parameter bit PLUS = 1'b0,
  localparam int RW  = N + (PLUS ? 1 : 0)
) (
  input  logic [2*N-1:0] v_i,
  output logic [RW-1:0]  r_o
);
  generate
    if (PLUS) begin : g_plus
      // 2^N == -1: low half minus high half
      rns_mod_addsub #(.W(N), .PLUS(1'b1), .SUB(1'b1)) u_sub (
        .a_i ({1'b0, v_i[N-1:0]}),
        .b_i ({1'b0, v_i[2*N-1:N]}),
        .r_o (r_o)
      );
    end else begin : g_minus
      // 2^N == 1: low half plus high half
      rns_mod_addsub #(.W(N), .PLUS(1'b0), .SUB(1'b0)) u_add (
        .a_i (v_i[N-1:0]),
        .b_i (v_i[2*N-1:N]),
        .r_o (r_o)
      );
    end
  endgenerate
endmodule

// File: rtl/rns_quot_core.sv
// Shared terms: h = X/m1 mod m2, t = floor(X/(m1*m2)).
module rns_quot_core #(
  parameter int N = 4,
  localparam int W2 = 2 * N
) (
  input  logic [W2:0]   x1_i,
  input  logic [W2-1:0] x2_i,
  input  logic [N:0]    x3_i,
  input  logic [N-1:0]  x4_i,
  output logic [W2-1:0] h_o,
  output logic [W2-1:0] t_o
);
  localparam logic [N+1:0]  M3  = (N+2)'((1 << N) + 1);
  localparam logic [W2:0]   MSH = (W2+1)'((1 << W2) - 1);

  logic [N:0]    dif, q;
  logic [N+1:0]  dodd;
  logic [W2:0]   y_w;
  logic [W2-1:0] y, s0, s1, s2, h_rot;

  // h = x2 - x1 mod 2^2N, carry-in one on complemented x1
  assign h_o = x2_i + (~x1_i[W2-1:0]) + W2'(1);

  // Y = X mod (2^2N-1) from x3, x4: q = (x4 - x3)/2 mod m3
  rns_mod_addsub #(.W(N), .PLUS(1'b1), .SUB(1'b1)) u_dif (
    .a_i ({1'b0, x4_i}),
    .b_i (x3_i),
    .r_o (dif)
  );

  always_comb begin
    dodd = (N+2)'(dif) + M3;
    q    = dif[0] ? dodd[N+1:1] : {1'b0, dif[N:1]};
    y_w  = (W2+1)'(x4_i) + ((W2+1)'(q) << N) - (W2+1)'(q);
    y    = y_w[W2-1:0];
  end

  always_comb begin
    AST_Y_RANGE: assert (y_w < MSH) else $error("recombined value out of range"); // R2
  end

  // t = (Y - x1 - 2h) / 2 mod 2^2N-1
  assign h_rot = {h_o[W2-2:0], h_o[W2-1]};

  rns_mod_addsub #(.W(W2), .PLUS(1'b0), .SUB(1'b1)) u_s0 (
    .a_i (y), .b_i (x1_i[W2-1:0]), .r_o (s0)
  );
  rns_mod_addsub #(.W(W2), .PLUS(1'b0), .SUB(1'b1)) u_s1 (
    .a_i (s0), .b_i (W2'(x1_i[W2])), .r_o (s1)
  );
  rns_mod_addsub #(.W(W2), .PLUS(1'b0), .SUB(1'b1)) u_s2 (
    .a_i (s1), .b_i (h_rot), .r_o (s2)
  );

  assign t_o = {s2[0], s2[W2-1:1]};
endmodule

// File: rtl/rns_zero_sel.sv
module rns_zero_sel #(
  parameter int N = 4,
  localparam int W2 = 2 * N
) (
  input  logic [W2:0]   lo1_i,
  input  logic [W2-1:0] lo2_i,
  input  logic [N:0]    lo3_i,
  input  logic [N-1:0]  lo4_i,
  input  logic [W2:0]   hi1_i,
  input  logic [W2-1:0] hi2_i,
  input  logic [N:0]    hi3_i,
  input  logic [N-1:0]  hi4_i,
  input  logic [W2:0]   x1_i,
  input  logic [W2-1:0] x2_i,
  input  logic [N:0]    x3_i,
  input  logic [N-1:0]  x4_i,
  output logic [W2:0]   s1_o,
  output logic [W2-1:0] s2_o,
  output logic [N:0]    s3_o,
  output logic [N-1:0]  s4_o,
  output logic [1:0]    src_o
);
  import rns_scale_pkg::*;

  logic lo_nz, hi_nz, x_nz;
  src_e src;

  assign lo_nz = |{lo1_i, lo2_i, lo3_i, lo4_i};
  assign hi_nz = |{hi1_i, hi2_i, hi3_i, hi4_i};
  assign x_nz  = |{x1_i, x2_i, x3_i, x4_i};

  always_comb begin
    if (lo_nz) begin
      src = SRC_LOW;
      {s1_o, s2_o, s3_o, s4_o} = {lo1_i, lo2_i, lo3_i, lo4_i};
    end else if (hi_nz) begin
      src = SRC_HIGH;
      {s1_o, s2_o, s3_o, s4_o} = {hi1_i, hi2_i, hi3_i, hi4_i};
    end else begin
      src = SRC_PASS;
      {s1_o, s2_o, s3_o, s4_o} = {x1_i, x2_i, x3_i, x4_i};
    end
  end
  assign src_o = src;

  always_comb begin
    AST_FINE_ZERO_COARSE_ZERO: assert (hi_nz || !lo_nz) else $error("coarse non-zero with fine zero"); // R7
    AST_SEL_NONZERO: assert (!x_nz || (|{s1_o, s2_o, s3_o, s4_o})) else $error("zero out for non-zero in"); // R8
  end
endmodule

// File: rtl/rns_dual_scaler.sv
module rns_dual_scaler #(
  parameter int N = 4,
  localparam int W2 = 2 * N
) (
  input  logic [W2:0]   x1_i,
  input  logic [W2-1:0] x2_i,
  input  logic [N:0]    x3_i,
  input  logic [N-1:0]  x4_i,
  output logic [W2:0]   lo1_o,
  output logic [W2-1:0] lo2_o,
  output logic [N:0]    lo3_o,
  output logic [N-1:0]  lo4_o,
  output logic [W2:0]   hi1_o,
  output logic [W2-1:0] hi2_o,
  output logic [N:0]    hi3_o,
  output logic [N-1:0]  hi4_o,
  output logic [W2:0]   sel1_o,
  output logic [W2-1:0] sel2_o,
  output logic [N:0]    sel3_o,
  output logic [N-1:0]  sel4_o,
  output logic [1:0]    src_o
);
  logic [W2-1:0] h, t;
  logic [N:0]    h3;
  logic [N-1:0]  h4;

  rns_quot_core #(.N(N)) u_core (
    .x1_i (x1_i), .x2_i (x2_i), .x3_i (x3_i), .x4_i (x4_i),
    .h_o  (h),    .t_o  (t)
  );

  // coarse quotient: t fits both large moduli directly
  assign lo1_o = {1'b0, t};
  assign lo2_o = t;

  rns_fold #(.N(N), .PLUS(1'b1)) u_lo3 (.v_i (t), .r_o (lo3_o));
  rns_fold #(.N(N), .PLUS(1'b0)) u_lo4 (.v_i (t), .r_o (lo4_o));

  // fine quotient = h + 2^2N * t
  assign hi2_o = h;

  rns_mod_addsub #(.W(W2), .PLUS(1'b1), .SUB(1'b1)) u_hi1 (
    .a_i ({1'b0, h}), .b_i ({1'b0, t}), .r_o (hi1_o)
  );

  rns_fold #(.N(N), .PLUS(1'b1)) u_h3 (.v_i (h), .r_o (h3));
  rns_fold #(.N(N), .PLUS(1'b0)) u_h4 (.v_i (h), .r_o (h4));

  rns_mod_addsub #(.W(N), .PLUS(1'b1), .SUB(1'b0)) u_hi3 (
    .a_i (h3), .b_i (lo3_o), .r_o (hi3_o)
  );
  rns_mod_addsub #(.W(N), .PLUS(1'b0), .SUB(1'b0)) u_hi4 (
    .a_i (h4), .b_i (lo4_o), .r_o (hi4_o)
  );

  rns_zero_sel #(.N(N)) u_sel (
    .lo1_i (lo1_o), .lo2_i (lo2_o), .lo3_i (lo3_o), .lo4_i (lo4_o),
    .hi1_i (hi1_o), .hi2_i (hi2_o), .hi3_i (hi3_o), .hi4_i (hi4_o),
    .x1_i  (x1_i),  .x2_i  (x2_i),  .x3_i  (x3_i),  .x4_i  (x4_i),
    .s1_o  (sel1_o), .s2_o (sel2_o), .s3_o (sel3_o), .s4_o (sel4_o),
    .src_o (src_o)
  );

  always_comb begin
    AST_HI1_BELOW_M1: assert ({1'b0, hi1_o} < (W2+2)'((1 << W2) + 1)) else $error("hi1 out of range"); // R4
    AST_LO_ZERO_MATCH: assert ((t == '0) == ({lo3_o, lo4_o} == '0) || t != '0) else $error("zero t gave non-zero residue"); // R3
  end
endmodule

// File: tb/sim_rns_dual_scaler.sv
module sim_rns_dual_scaler;
  localparam int N  = 3;
  localparam int W2 = 2 * N;
  localparam longint M1 = (1 << W2) + 1;
  localparam longint M2 = (1 << W2);
  localparam longint M3 = (1 << N) + 1;
  localparam longint M4 = (1 << N) - 1;
  localparam longint RANGE = M1 * M2 * M3 * M4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W2:0]   x1, lo1, hi1, s1;
  logic [W2-1:0] x2, lo2, hi2, s2;
  logic [N:0]    x3, lo3, hi3, s3;
  logic [N-1:0]  x4, lo4, hi4, s4;
  logic [1:0]    src;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  rns_dual_scaler #(.N(N)) u0 (
    .x1_i (x1), .x2_i (x2), .x3_i (x3), .x4_i (x4),
    .lo1_o (lo1), .lo2_o (lo2), .lo3_o (lo3), .lo4_o (lo4),
    .hi1_o (hi1), .hi2_o (hi2), .hi3_o (hi3), .hi4_o (hi4),
    .sel1_o (s1), .sel2_o (s2), .sel3_o (s3), .sel4_o (s4),
    .src_o (src)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_x(input longint xv);
    longint t, q, el1, el2, el3, el4, eh1, eh2, eh3, eh4;
    longint e1, e2, e3, e4, es;
    x1 = W2'(0) + (W2+1)'(xv % M1);
    x2 = W2'(xv % M2);
    x3 = (N+1)'(xv % M3);
    x4 = N'(xv % M4);
    #1;
    t = xv / (M1 * M2);
    q = xv / M1;
    el1 = t % M1; el2 = t % M2; el3 = t % M3; el4 = t % M4;
    eh1 = q % M1; eh2 = q % M2; eh3 = q % M3; eh4 = q % M4;
    chk("R1 hi2", longint'(hi2), eh2);
    chk("R2 lo1", longint'(lo1), el1);
    chk("R2 lo2", longint'(lo2), el2);
    chk("R3 lo3", longint'(lo3), el3);
    chk("R3 lo4", longint'(lo4), el4);
    chk("R4 hi1", longint'(hi1), eh1);
    chk("R5 hi3", longint'(hi3), eh3);
    chk("R5 hi4", longint'(hi4), eh4);
    chk("R9 range", longint'(lo4 < N'(M4) && hi4 < N'(M4) && lo3 < (N+1)'(M3)
                    && hi3 < (N+1)'(M3) && hi1 < (W2+1)'(M1)), 1);
    if (el1 | el2 | el3 | el4) begin
      e1 = el1; e2 = el2; e3 = el3; e4 = el4; es = 0;
      chk("R6 src", longint'(src), es);
      chk("R6 sel", longint'({s1, s2, s3, s4}), longint'({e1[W2:0], e2[W2-1:0], e3[N:0], e4[N-1:0]}));
    end else if (eh1 | eh2 | eh3 | eh4) begin
      e1 = eh1; e2 = eh2; e3 = eh3; e4 = eh4; es = 1;
      chk("R7 src", longint'(src), es);
      chk("R7 sel", longint'({s1, s2, s3, s4}), longint'({e1[W2:0], e2[W2-1:0], e3[N:0], e4[N-1:0]}));
    end else begin
      es = 2;
      chk("R8 src", longint'(src), es);
      chk("R8 sel", longint'({s1, s2, s3, s4}), longint'({x1, x2, x3, x4}));
    end
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    x1 = '0; x2 = '0; x3 = '0; x4 = '0;
    #2;
    // all-zero input passes through with code 10
    chk("R8 zero src", longint'(src), 2);
    chk("R8 zero sel", longint'({s1, s2, s3, s4}), 0);
    // boundaries: coarse/fine and fine/pass edges, top of range
    run_x(M1 * M2);
    run_x(M1 * M2 - 1);
    run_x(M1);
    run_x(M1 - 1);
    run_x(RANGE - 1);
    for (longint xv = 1; xv < RANGE; xv++) run_x(xv);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule